// File: doc/BRIEF.md
# Host Command Legality and Interrupt Unit

This unit sits between a host register port and the bus sequencer of a simple parallel-bus peripheral controller. When the host writes an 8-bit command, the unit splits it into a 7-bit operation code and a DMA request flag. It then decides whether the operation is allowed in the controller's present connection state and bus phase. The connection state and phase arrive as inputs from the sequencer.

An allowed command leaves the unit on a single-cycle strobe that carries its operation code and DMA flag. A refused command produces no strobe and raises the illegal-command cause in the interrupt register.

The interrupt register collects causes from three sources: pulses from the sequencer, command refusal and bus-reset commands. It is cleared when read. A pending output stays high while any cause bit is set.

Top module: `cmd_gate`

## Requirements
- R1: A command write in cycle N that is accepted yields `go_stb` high for exactly cycle N+1, with `go_op` equal to command bits 6..0 and `go_dma` equal to command bit 7.
- R2: Operation codes 0x00 (no-op), 0x01 (flush), 0x02 (controller reset) and 0x03 (bus reset) are accepted in every state and phase.
- R3: Codes 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B are accepted only while `conn_init` is high.
- R4: Codes 0x20 through 0x25 and 0x27 through 0x2B are accepted only while `conn_init` is high and `phase` is 3'b110 (message out) or 3'b111 (message in).
- R5: Codes 0x40 through 0x47 are accepted only while `conn_dis` is high.
- R6: Any command that is not accepted, including a code in no group (for example 0x26 or 0x7F), sets interrupt bit 6 (0x40) in the following cycle and gives no strobe.
- R7: An accepted bus-reset command (0x03) sets interrupt bit 7 (0x80) unless `busrst_quiet` is high. The other codes below 0x04 set no interrupt bit.
- R8: Each high bit of `evt_set` sets the interrupt bit at the same position in the following cycle. The positions are: 0 select without attention, 1 select with attention, 2 reselected, 3 function done, 4 bus service, 5 disconnect.
- R9: `irq_q` shows the interrupt register. In a cycle with `irq_rd` high, the register is cleared at the next edge, except for causes that arrive in that same cycle, which remain set.
- R10: `irq_pend` is high exactly when `irq_q` is non-zero.
- R11: After reset, `irq_q` is zero and both `irq_pend` and `go_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte: bit 7 DMA, bits 6..0 operation |
| conn_dis | input | 1 | Controller is disconnected |
| conn_init | input | 1 | Controller is connected as initiator |
| phase | input | 3 | Bus phase {MSG, C/D, I/O} |
| busrst_quiet | input | 1 | Suppress the bus-reset interrupt cause |
| evt_set | input | 8 | Interrupt cause pulses from the sequencer |
| irq_rd | input | 1 | Host reads the interrupt register |
| irq_q | output | 8 | Interrupt register contents |
| irq_pend | output | 1 | Any interrupt cause set |
| go_stb | output | 1 | Accepted command strobe |
| go_op | output | 7 | Operation code of the accepted command |
| go_dma | output | 1 | DMA flag of the accepted command |

## Verification
The bench builds the unit with its default phase encodings, 3'b110 for message out and 3'b111 for message in. These defaults make the message-phase gating of the third group reachable from random phase values.

Random codes are biased toward the defined groups and also cover the whole 7-bit space, so the bench exercises the gaps such as 0x26 and 0x13 in every connection state. Directed cases cover the following:
- a bus reset with and without suppression;
- a read that coincides with a refusal or a sequencer pulse;
- events that accumulate across several cycles before a read.

// File: rtl/cmd_gate.sv
module cmd_gate #(
  parameter logic [2:0] PH_MSGOUT = 3'b110,
  parameter logic [2:0] PH_MSGIN  = 3'b111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  input  logic       conn_dis,
  input  logic       conn_init,
  input  logic [2:0] phase,
  input  logic       busrst_quiet,
  input  logic [7:0] evt_set,
  input  logic       irq_rd,
  output logic [7:0] irq_q,
  output logic       irq_pend,
  output logic       go_stb,
  output logic [6:0] go_op,
  output logic       go_dma
);

  localparam int ILL_BIT  = 6;
  localparam int BRST_BIT = 7;

  logic [6:0] op;
  logic       g1, g2, g3, g4, msg_ph, legal;
  logic [7:0] irq_r, irq_set;

  assign op     = cmd_data[6:0];
  assign msg_ph = (phase == PH_MSGOUT) || (phase == PH_MSGIN);

  always_comb begin
    g1 = (op <= 7'h03);
    g2 = 1'b0;
    case (op)
      7'h10, 7'h11, 7'h12, 7'h18, 7'h1A, 7'h1B: g2 = 1'b1;
      default: g2 = 1'b0;
    endcase
    g3 = ((op >= 7'h20) && (op <= 7'h25)) || ((op >= 7'h27) && (op <= 7'h2B));
    g4 = (op >= 7'h40) && (op <= 7'h47);
    legal = g1 | (g2 & conn_init) | (g3 & conn_init & msg_ph) | (g4 & conn_dis);
  end

  always_comb begin
    irq_set = evt_set;
    if (cmd_we && !legal) irq_set[ILL_BIT] = 1'b1;
    if (cmd_we && op == 7'h03 && !busrst_quiet) irq_set[BRST_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_r  <= '0;
      go_stb <= 1'b0;
      go_op  <= '0;
      go_dma <= 1'b0;
    end else begin
      irq_r  <= (irq_rd ? 8'h00 : irq_r) | irq_set;
      go_stb <= cmd_we & legal;
      go_op  <= op;
      go_dma <= cmd_data[7];
    end
  end

  assign irq_q    = irq_r;
  assign irq_pend = |irq_r;

  // R6
  gap_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[6:0] == 7'h26) |=> (!go_stb && irq_q[6]));

  // R1
  stb_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_stb |-> $past(cmd_we));

  // R5
  g4_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[6:3] == 4'b1000 && conn_dis) |=> go_stb);

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd && evt_set == 8'h00 && !cmd_we) |=> (irq_q == 8'h00));

  // R7
  quiet_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[6:0] == 7'h03 && busrst_quiet && !irq_q[7] && !evt_set[7]) |=> !irq_q[7]);

endmodule

// File: tb/sim_cmd_gate.sv
module sim_cmd_gate;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_we = 0, conn_dis = 0, conn_init = 0, busrst_quiet = 0, irq_rd = 0;
  logic [7:0] cmd_data = 0, evt_set = 0;
  logic [2:0] phase = 0;
  logic [7:0] irq_q;
  logic irq_pend, go_stb, go_dma;
  logic [6:0] go_op;

  int n_chk = 0, n_bad = 0;
  logic [7:0] e_irq = 0;
  logic e_stb = 0, e_dma = 0;
  logic [6:0] e_op = 0;

  always #(PERIOD/2) clk = ~clk;

  cmd_gate u0 (.clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .conn_dis(conn_dis), .conn_init(conn_init), .phase(phase),
    .busrst_quiet(busrst_quiet), .evt_set(evt_set), .irq_rd(irq_rd),
    .irq_q(irq_q), .irq_pend(irq_pend), .go_stb(go_stb), .go_op(go_op), .go_dma(go_dma));

  function automatic logic ok(logic [6:0] op, logic dis, logic ini, logic [2:0] ph);
    logic m = (ph == 3'b110) || (ph == 3'b111);
    if (op <= 7'h03) return 1'b1;
    if (op == 7'h10 || op == 7'h11 || op == 7'h12 || op == 7'h18 || op == 7'h1A || op == 7'h1B) return ini;
    if ((op >= 7'h20 && op <= 7'h25) || (op >= 7'h27 && op <= 7'h2B)) return ini && m;
    if (op >= 7'h40 && op <= 7'h47) return dis;
    return 1'b0;
  endfunction

  function automatic string gtag(logic [6:0] op, logic legal);
    if (!legal) return "R6";
    if (op <= 7'h03) return "R2";
    if (op < 7'h20) return "R3";
    if (op < 7'h40) return "R4";
    return "R5";
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [7:0] d, logic dis, logic ini, logic [2:0] ph,
                     logic q, logic [7:0] ev, logic rd, string tag);
    logic lg;
    logic [7:0] s;
    cmd_we = we; cmd_data = d; conn_dis = dis; conn_init = ini; phase = ph;
    busrst_quiet = q; evt_set = ev; irq_rd = rd;
    lg = ok(d[6:0], dis, ini, ph);
    s = ev;
    if (we && !lg) s[6] = 1'b1;
    if (we && d[6:0] == 7'h03 && !q) s[7] = 1'b1;
    @(negedge clk);
    e_irq = (rd ? 8'h00 : e_irq) | s;
    e_stb = we & lg;
    e_op = d[6:0];
    e_dma = d[7];
    chk(tag == "" ? gtag(d[6:0], lg) : tag, "go_stb", go_stb, e_stb);
    if (e_stb) begin
      chk("R1", "go_op", go_op, e_op);
      chk("R1", "go_dma", go_dma, e_dma);
    end
    chk(tag == "" ? "R9" : tag, "irq_q", irq_q, e_irq);
    chk("R10", "irq_pend", irq_pend, |e_irq);
  endtask

  task automatic idle(string tag);
    cyc(0, 8'h00, 0, 0, 3'b000, 0, 8'h00, 0, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    chk("R11", "irq_q", irq_q, 0);
    chk("R11", "irq_pend", irq_pend, 0);
    chk("R11", "go_stb", go_stb, 0);
    rst_n = 1;
    idle("R11");

    cyc(1, 8'h82, 0, 0, 3'b000, 0, 8'h00, 0, "R2");
    cyc(1, 8'h01, 0, 1, 3'b010, 0, 8'h00, 0, "R7");
    cyc(1, 8'h03, 1, 0, 3'b001, 1, 8'h00, 0, "R7");
    cyc(1, 8'h03, 1, 0, 3'b001, 0, 8'h00, 0, "R7");
    cyc(0, 8'h00, 0, 0, 3'b000, 0, 8'h00, 1, "R9");
    cyc(1, 8'h11, 1, 0, 3'b000, 0, 8'h00, 0, "R3");
    cyc(1, 8'h9A, 0, 1, 3'b000, 0, 8'h00, 1, "R3");
    cyc(1, 8'h22, 0, 1, 3'b010, 0, 8'h00, 1, "R4");
    cyc(1, 8'hAB, 0, 1, 3'b111, 0, 8'h00, 1, "R4");
    cyc(1, 8'h27, 0, 1, 3'b110, 0, 8'h00, 0, "R4");
    cyc(1, 8'h26, 0, 1, 3'b110, 0, 8'h00, 1, "R6");
    cyc(1, 8'h7F, 1, 1, 3'b111, 0, 8'h00, 1, "R6");
    cyc(1, 8'hC7, 1, 0, 3'b000, 0, 8'h00, 1, "R5");
    cyc(1, 8'h41, 0, 1, 3'b000, 0, 8'h00, 1, "R5");
    cyc(0, 8'h00, 0, 0, 3'b000, 0, 8'h01, 1, "R8");
    cyc(0, 8'h00, 0, 0, 3'b000, 0, 8'h24, 0, "R8");
    cyc(0, 8'h00, 0, 0, 3'b000, 0, 8'h18, 0, "R8");
    cyc(0, 8'h00, 0, 0, 3'b000, 0, 8'h02, 1, "R9");
    idle("R9");
    cyc(0, 8'h00, 0, 0, 3'b000, 0, 8'h00, 1, "R10");

    for (int i = 0; i < 4000; i++) begin
      logic [6:0] op;
      case ($urandom % 4)
        0: op = 7'($urandom % 4);
        1: case ($urandom % 6)
             0: op = 7'h10; 1: op = 7'h11; 2: op = 7'h12;
             3: op = 7'h18; 4: op = 7'h1A; default: op = 7'h1B;
           endcase
        2: op = 7'(7'h20 + $urandom % 12);
        default: op = 7'($urandom % 128);
      endcase
      if ($urandom % 5 == 0) op = 7'(7'h40 + $urandom % 8);
      cyc(1'($urandom % 2), {1'($urandom), op}, 1'($urandom), 1'($urandom),
          3'($urandom), 1'($urandom), ($urandom % 8 == 0) ? 8'($urandom) : 8'h00,
          ($urandom % 4 == 0), "");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule